// File: doc/BRIEF.md
# Iterative Radix-2 Real-Input FFT Engine

This block computes an N-point discrete Fourier transform of real samples in Q1.15 fixed point. It keeps all data in one dual-port memory and reuses one butterfly unit for every operation. A sample written through the load port goes into the memory at the bit-reversed position of its index, with its imaginary part set to zero. Because the input is stored in that order, the complex bins come out in natural order without any reordering pass.

A pulse on `start` runs log2(N) passes over the memory. Each pass performs N/2 butterflies, and each butterfly takes two cycles: one to read the pair, one to write it back. Every butterfly result is halved with round-half-up, so the stored magnitude never grows and the final bins equal the DFT divided by N. When the last pair is written, `done` pulses for one cycle. The host can then fetch any bin through the read port, one cycle after presenting its index. The twiddle factors are a constant table that is computed when the design is elaborated. N defaults to 64; 128 is also supported.

Top module: `fft_engine`

## Requirements
- R1: During and after reset, `busy` and `done` are both 0.
- R2: While idle, a write with `load_en`=1 stores `load_sample` as the real part and 0 as the imaginary part. It goes to the memory location whose index is `load_idx` with its log2(N) bits reversed (bit 0 swapped with the top bit, and so on).
- R3: A `start` pulse while idle holds `busy` at 1 for exactly N*log2(N) cycles. After that, `done` is 1 for exactly one cycle and `busy` is 0.
- R4: After `done`, reading index k returns bin k in natural order: real part = round(sum of x[n]*cos(2*pi*k*n/N) / N), imaginary part = round(-sum of x[n]*sin(2*pi*k*n/N) / N), each within 8 LSB.
- R5: Full-scale inputs never overflow a butterfly. An all -32768 input gives a bin 0 real part within 8 LSB of -32768. A +/-24000 alternating input gives a bin N/2 real part within 8 LSB of 24000. All other bins stay within 8 LSB of 0.
- R6: While `busy` is 1, `start` and `load_en` are ignored: the run length and the resulting bins are the same as in an undisturbed run.
- R7: Input round(16384*cos(2*pi*4*n/N)) gives real parts of about 8192 at bins 4 and N-4, and values within 8 LSB of 0 elsewhere.
- R8: While idle, `rd_re`/`rd_im` show the memory entry addressed by the `rd_idx` value sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Write one input sample (ignored while busy) |
| load_idx | input | log2(N) | Natural-order index of the sample |
| load_sample | input | 16 | Real sample, Q1.15 signed |
| start | input | 1 | Begin a transform (ignored while busy) |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle pulse when the transform completes |
| rd_idx | input | log2(N) | Bin index to read |
| rd_re | output | 16 | Real part of the addressed bin, Q1.15 signed |
| rd_im | output | 16 | Imaginary part of the addressed bin, Q1.15 signed |

## Verification
The hardest case to reach from the ports is a `start` or a `load_en` arriving in the middle of a transform. A restart there would reset the pass counter, and a load there would overwrite a partly transformed entry with no visible symptom until the bins are read. The stimulus handles this by reloading a known pseudo-random frame, starting it, and driving `start` together with a garbage load 50 cycles into the run. It then requires the exact run length and every bin of that frame to match a DFT computed in the bench. Overflow margins are reached with full-scale DC and alternating frames. Those frames push every butterfly to its largest magnitude.

// File: rtl/fft_pkg.sv
// Package: shared complex type and elaboration-time trigonometry for the FFT engine.
// Assumes: 16-bit Q1.15 data; the real-valued functions are used only for constants.
package fft_pkg;

    localparam int DW = 16;

    typedef struct packed {
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } cplx_t;

    localparam real PI_R = 3.14159265358979323846;

    // Sine by power series; accurate to far below one LSB for |x| <= pi.
    function automatic real series_sin(input real x);
        real term;
        real acc;
        term = x;
        acc  = x;
        for (int i = 1; i < 14; i++) begin
            term = -term * x * x / ((2.0 * i) * (2.0 * i + 1.0));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Cosine by power series; accurate to far below one LSB for |x| <= pi.
    function automatic real series_cos(input real x);
        real term;
        real acc;
        term = 1.0;
        acc  = 1.0;
        for (int i = 1; i < 14; i++) begin
            term = -term * x * x / ((2.0 * i - 1.0) * (2.0 * i));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Round a real in [-1, 1] to Q1.15, clamping +1.0 to the largest code.
    function automatic logic signed [DW-1:0] to_q15(input real v);
        real    sc;
        integer r;
        sc = v * 32768.0;
        if (sc >= 0.0) r = $rtoi(sc + 0.5);
        else           r = -$rtoi(0.5 - sc);
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return DW'(r);
    endfunction

endpackage

// File: rtl/fft_twiddle_rom.sv
// Module: constant twiddle table, W(k) = cos(2*pi*k/N) - j*sin(2*pi*k/N), k < N/2.
// Assumes: N is a power of two, at least 4; the read is purely combinational.
module fft_twiddle_rom
    import fft_pkg::*;
#(
    parameter int N = 64
) (
    input  logic [$clog2(N)-2:0] idx,
    output cplx_t                w
);
    localparam int HALF = N / 2;

    cplx_t tab [HALF];

    // One constant entry per twiddle angle, evaluated at elaboration.
    for (genvar k = 0; k < HALF; k++) begin : g_tw
        localparam real   ANG   = 2.0 * PI_R * real'(k) / real'(N);
        localparam cplx_t ENTRY = '{re: to_q15(series_cos(ANG)),
                                    im: to_q15(-series_sin(ANG))};
        assign tab[k] = ENTRY;
    end

    assign w = tab[idx];

endmodule

// File: rtl/fft_butterfly.sv
// Module: radix-2 decimation-in-time butterfly with a built-in halving.
//   p = round((a + w*b)/2), q = round((a - w*b)/2), each saturated to Q1.15.
// Assumes: |a|, |b| < 1 as complex magnitudes, so saturation never engages; ovf reports it.
module fft_butterfly
    import fft_pkg::*;
(
    input  cplx_t a,
    input  cplx_t b,
    input  cplx_t w,
    output cplx_t p,
    output cplx_t q,
    output logic  ovf
);
    localparam int MW = 2 * DW;
    localparam int PW = 2 * DW + 2;
    localparam logic signed [PW-1:0] RND  = PW'(1) <<< (DW - 1);
    localparam logic signed [PW-1:0] MAXV = PW'(32767);
    localparam logic signed [PW-1:0] MINV = -PW'(32768);

    logic signed [MW-1:0] m_rr, m_ii, m_ri, m_ir;
    logic signed [PW-1:0] t_re, t_im, a_re, a_im;
    logic signed [PW-1:0] raw [4];
    logic signed [DW-1:0] res [4];
    logic [3:0]           ovf_v;

    // Complex product, both sums/differences, rounding halving and clamp.
    always_comb begin
        m_rr = MW'(b.re) * MW'(w.re);
        m_ii = MW'(b.im) * MW'(w.im);
        m_ri = MW'(b.re) * MW'(w.im);
        m_ir = MW'(b.im) * MW'(w.re);
        t_re = PW'(m_rr) - PW'(m_ii);
        t_im = PW'(m_ri) + PW'(m_ir);
        a_re = PW'(a.re) <<< (DW - 1);
        a_im = PW'(a.im) <<< (DW - 1);
        raw[0] = (a_re + t_re + RND) >>> DW;
        raw[1] = (a_im + t_im + RND) >>> DW;
        raw[2] = (a_re - t_re + RND) >>> DW;
        raw[3] = (a_im - t_im + RND) >>> DW;
        for (int i = 0; i < 4; i++) begin
            ovf_v[i] = (raw[i] > MAXV) || (raw[i] < MINV);
            if (raw[i] > MAXV)      res[i] = DW'(32767);
            else if (raw[i] < MINV) res[i] = DW'(-32768);
            else                    res[i] = raw[i][DW-1:0];
        end
        p   = '{re: res[0], im: res[1]};
        q   = '{re: res[2], im: res[3]};
        ovf = |ovf_v;
    end

endmodule

// File: rtl/fft_dpram.sv
// Module: two-port data memory, each port with one-cycle registered read and write.
// Assumes: the two ports never write the same address in one cycle; contents are not reset.
module fft_dpram
    import fft_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic [$clog2(DEPTH)-1:0] addr_a,
    input  logic                     we_a,
    input  cplx_t                    wdata_a,
    output cplx_t                    rdata_a,
    input  logic [$clog2(DEPTH)-1:0] addr_b,
    input  logic                     we_b,
    input  cplx_t                    wdata_b,
    output cplx_t                    rdata_b
);
    cplx_t mem [DEPTH];

    // Both ports: optional write, registered read of the addressed entry.
    always_ff @(posedge clk) begin
        if (we_a) mem[addr_a] <= wdata_a;
        if (we_b) mem[addr_b] <= wdata_b;
        rdata_a <= mem[addr_a];
        rdata_b <= mem[addr_b];
    end

endmodule

// File: rtl/fft_ctrl.sv
// Module: pass/butterfly sequencer. Each butterfly uses a read cycle then a write cycle.
//   Pass s pairs entries half = 2^s apart; twiddle index = position << (log2(N)-1-s).
// Assumes: data was stored in bit-reversed order; start is honoured only when idle.
module fft_ctrl #(
    parameter int N = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    output logic                 busy,
    output logic                 done,
    output logic                 wr_en,
    output logic [$clog2(N)-1:0] addr_top,
    output logic [$clog2(N)-1:0] addr_bot,
    output logic [$clog2(N)-2:0] tw_idx
);
    localparam int AW   = $clog2(N);
    localparam int L    = AW;
    localparam int BW   = AW - 1;
    localparam int TW   = AW - 1;
    localparam int SW   = $clog2(L + 1);
    localparam int HALF = N / 2;
    localparam int RUN  = N * L;
    localparam int CW   = $clog2(RUN + 1) + 1;

    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} state_t;

    state_t        state;
    logic [SW-1:0] stage;
    logic [BW-1:0] bf;
    logic          last_bf, last_stage;
    logic [AW-1:0] bf_w, half, lowmask, grp, pos;

    assign last_bf    = (bf == BW'(HALF - 1));
    assign last_stage = (stage == SW'(L - 1));
    assign busy       = (state != ST_IDLE);
    assign wr_en      = (state == ST_WRITE);

    // Address generation for the current pair and its twiddle.
    always_comb begin
        bf_w     = AW'(bf);
        half     = AW'(1) << stage;
        lowmask  = half - AW'(1);
        pos      = bf_w & lowmask;
        grp      = (bf_w >> stage) << (stage + SW'(1));
        addr_top = grp | pos;
        addr_bot = addr_top | half;
        tw_idx   = TW'(pos << (SW'(L - 1) - stage));
    end

    // Sequencer: idle -> (read, write) per butterfly, passes in order, done pulse at end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            stage <= '0;
            bf    <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_READ;
                        stage <= '0;
                        bf    <= '0;
                    end
                end
                ST_READ: state <= ST_WRITE;
                ST_WRITE: begin
                    if (last_bf) begin
                        bf <= '0;
                        if (last_stage) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            stage <= stage + SW'(1);
                            state <= ST_READ;
                        end
                    end else begin
                        bf    <= bf + BW'(1);
                        state <= ST_READ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Independent run-length counter used only by the run-length check.
    logic [CW-1:0] run_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)             run_cnt <= '0;
        else if (start && !busy) run_cnt <= '0;
        else if (busy)          run_cnt <= run_cnt + CW'(1);
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == CW'(RUN))); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (stage >= $past(stage))); // R6
    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (addr_bot > addr_top)); // R4

endmodule

// File: rtl/fft_engine.sv
// Module: top of the iterative real-input FFT. Loads samples bit-reversed, runs the
//   sequencer over one dual-port memory with one butterfly, then serves bins by index.
// Assumes: N is a power of two (default 64, 128 supported); host reads only while idle.
module fft_engine
    import fft_pkg::*;
#(
    parameter int N = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_en,
    input  logic [$clog2(N)-1:0]    load_idx,
    input  logic signed [DW-1:0]    load_sample,
    input  logic                    start,
    output logic                    busy,
    output logic                    done,
    input  logic [$clog2(N)-1:0]    rd_idx,
    output logic signed [DW-1:0]    rd_re,
    output logic signed [DW-1:0]    rd_im
);
    localparam int AW = $clog2(N);

    logic          wr_en, bf_ovf;
    logic [AW-1:0] addr_top, addr_bot, load_rev;
    logic [AW-2:0] tw_idx;
    cplx_t         tw, top_q, bot_q, res_p, res_q;
    logic [AW-1:0] addr_a, addr_b;
    logic          we_a, we_b;
    cplx_t         wdata_a;

    // Reverse the natural load index into the storage index.
    always_comb begin
        for (int i = 0; i < AW; i++) load_rev[i] = load_idx[AW-1-i];
    end

    // Memory ports: engine owns both while busy; host load on A, host read on B when idle.
    always_comb begin
        if (busy) begin
            addr_a  = addr_top;
            we_a    = wr_en;
            wdata_a = res_p;
            addr_b  = addr_bot;
            we_b    = wr_en;
        end else begin
            addr_a  = load_rev;
            we_a    = load_en;
            wdata_a = '{re: load_sample, im: '0};
            addr_b  = rd_idx;
            we_b    = 1'b0;
        end
    end

    fft_ctrl #(.N(N)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .busy     (busy),
        .done     (done),
        .wr_en    (wr_en),
        .addr_top (addr_top),
        .addr_bot (addr_bot),
        .tw_idx   (tw_idx)
    );

    fft_twiddle_rom #(.N(N)) u_rom (
        .idx (tw_idx),
        .w   (tw)
    );

    fft_dpram #(.DEPTH(N)) u_mem (
        .clk     (clk),
        .addr_a  (addr_a),
        .we_a    (we_a),
        .wdata_a (wdata_a),
        .rdata_a (top_q),
        .addr_b  (addr_b),
        .we_b    (we_b),
        .wdata_b (res_q),
        .rdata_b (bot_q)
    );

    fft_butterfly u_bfly (
        .a   (top_q),
        .b   (bot_q),
        .w   (tw),
        .p   (res_p),
        .q   (res_q),
        .ovf (bf_ovf)
    );

    assign rd_re = bot_q.re;
    assign rd_im = bot_q.im;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !bf_ovf); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (!done || $past(busy))); // R1

endmodule

// File: tb/tb_fft_engine.sv
`timescale 1ns/1ps
module tb_fft_engine;
    localparam int N   = 64;
    localparam int AW  = $clog2(N);
    localparam int RUN = N * AW;
    localparam real PI = 3.14159265358979323846;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 load_en = 1'b0;
    logic [AW-1:0]        load_idx = '0;
    logic signed [15:0]   load_sample = '0;
    logic                 start = 1'b0;
    logic                 busy, done;
    logic [AW-1:0]        rd_idx = '0;
    logic signed [15:0]   rd_re, rd_im;

    always #2.5 clk = ~clk;

    fft_engine #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
        .load_sample(load_sample), .start(start), .busy(busy), .done(done),
        .rd_idx(rd_idx), .rd_re(rd_re), .rd_im(rd_im)
    );

    typedef struct { int re; int im; int tol; string tag; } exp_t;
    exp_t  sbq[$];
    exp_t  mon_e;
    int    checks = 0;
    int    failures = 0;
    int    xin [N];
    logic  rd_req = 1'b0;
    logic  req_d = 1'b0;

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int rnd(input real v);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
    endfunction

    function automatic int brev(input int v);
        int r = 0;
        for (int i = 0; i < AW; i++) if (v[i]) r = r | (1 << (AW - 1 - i));
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: read data is due one cycle after the index (R8); pop and compare.
    always @(posedge clk) req_d <= rd_req;
    always @(negedge clk) begin
        if (req_d) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R8", "unexpected read result", int'(rd_re), 0);
            end else begin
                mon_e = sbq.pop_front();
                checks++;
                if (iabs(int'(rd_re) - mon_e.re) > mon_e.tol ||
                    iabs(int'(rd_im) - mon_e.im) > mon_e.tol) begin
                    failures++;
                    $display("FAIL %s bin actual=(%0d,%0d) expected=(%0d,%0d)",
                             mon_e.tag, rd_re, rd_im, mon_e.re, mon_e.im);
                end
            end
        end
    end

    // Driver: expected bins from a direct DFT divided by N.
    task automatic push_dft(input string tag);
        for (int k = 0; k < N; k++) begin
            real sre = 0.0;
            real sim = 0.0;
            exp_t e;
            for (int n = 0; n < N; n++) begin
                real ang = 2.0 * PI * real'((k * n) % N) / real'(N);
                sre = sre + real'(xin[n]) * $cos(ang);
                sim = sim - real'(xin[n]) * $sin(ang);
            end
            e.re = rnd(sre / N); e.im = rnd(sim / N); e.tol = 8; e.tag = tag;
            sbq.push_back(e);
        end
    endtask

    // Driver: stored layout before the run, entry k holds sample brev(k) (R2).
    task automatic push_layout();
        for (int k = 0; k < N; k++) begin
            exp_t e;
            e.re = xin[brev(k)]; e.im = 0; e.tol = 0; e.tag = "R2 R8";
            sbq.push_back(e);
        end
    endtask

    task automatic load_all();
        for (int i = 0; i < N; i++) begin
            @(posedge clk); #1;
            load_en = 1'b1; load_idx = AW'(i); load_sample = 16'(xin[i]);
        end
        @(posedge clk); #1;
        load_en = 1'b0;
    endtask

    task automatic read_all();
        for (int k = 0; k < N; k++) begin
            @(posedge clk); #1;
            rd_idx = AW'(k); rd_req = 1'b1;
        end
        @(posedge clk); #1;
        rd_req = 1'b0;
        repeat (2) @(posedge clk);
        check(sbq.size() == 0, "R4", "scoreboard left over", sbq.size(), 0);
    endtask

    // Start a run, optionally poke start/load mid-run, and measure busy length.
    task automatic run_fft(input bit disturb, input string tag);
        int cyc = 0;
        bit seen = 0;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        while (!seen && cyc < 2 * RUN) begin
            @(negedge clk);
            if (done) seen = 1;
            else if (busy) cyc++;
            if (disturb && cyc == 50) begin
                start = 1'b1; load_en = 1'b1; load_idx = '0; load_sample = 16'sd12345;
            end else begin
                start = 1'b0; load_en = 1'b0;
            end
        end
        check(seen && cyc == RUN, tag, "busy cycles before done", cyc, RUN);
        @(negedge clk);
        check(!done && !busy, tag, "done pulse width / idle after", int'(done), 0);
    endtask

    initial begin
        logic [31:0] seed;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!busy && !done, "R1", "busy/done in reset", int'({busy, done}), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !done, "R1", "busy/done after reset", int'({busy, done}), 0);

        // Impulse: layout check, then flat spectrum of 16384/N.
        for (int n = 0; n < N; n++) xin[n] = 0;
        xin[0] = 16384;
        load_all(); push_layout(); read_all();
        run_fft(1'b0, "R3"); push_dft("R4"); read_all();

        // Cosine at bin 4, amplitude 0.5.
        for (int n = 0; n < N; n++) xin[n] = rnd(16384.0 * $cos(2.0 * PI * 4.0 * n / N));
        load_all(); push_layout(); read_all();
        run_fft(1'b0, "R3"); push_dft("R7"); read_all();

        // Full-scale negative DC.
        for (int n = 0; n < N; n++) xin[n] = -32768;
        load_all(); run_fft(1'b0, "R3"); push_dft("R5"); read_all();

        // Alternating +/-24000 (energy at bin N/2).
        for (int n = 0; n < N; n++) xin[n] = (n % 2 == 0) ? 24000 : -24000;
        load_all(); run_fft(1'b0, "R3"); push_dft("R5"); read_all();

        // Pseudo-random frame, clean run.
        seed = 32'h1234_5678;
        for (int n = 0; n < N; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            xin[n] = int'($signed(seed[30:15]));
        end
        load_all(); run_fft(1'b0, "R3"); push_dft("R4"); read_all();

        // Same frame, with start and load poked mid-run: must be ignored.
        load_all(); run_fft(1'b1, "R6"); push_dft("R6"); read_all();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule